// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds the integer general-purpose registers of a 64-bit core: sixteen entries of 64 bits, each reachable through narrower views that alias its low bits. Two read ports and one write port each carry a register index and a size code. A read hands back the chosen slice, zero-extended to 64 bits. A write either merges the new bits into the stored value or replaces it, depending on the view.

Views that are narrower than 32 bits leave every bit outside their slice untouched. A 32-bit write also clears the upper half of the register. Indices 0 to 3 offer a second byte view on bits 15:8. Any other index used with that view is flagged on the port, and a write through such a flag is dropped. The two pointer registers are ordinary entries and get no special treatment. Reads are combinational. Writes land on the rising clock edge.

Top module: `alias_regfile`

## Requirements
- R1: Reset clears all sixteen registers to zero, and every full-width read after reset returns zero.
- R2: A write with size code 4 (full) replaces all 64 bits of the addressed register.
- R3: A write with size code 3 (32-bit) stores wr_data[31:0] in bits 31:0 and clears bits 63:32.
- R4: A write with size code 2 (16-bit) stores wr_data[15:0] in bits 15:0 and keeps bits 63:16.
- R5: A write with size code 0 (low byte) stores wr_data[7:0] in bits 7:0 and keeps bits 63:8.
- R6: A write with size code 1 (high byte) to index 0..3 stores wr_data[7:0] in bits 15:8 and keeps all other bits.
- R7: A read returns the view zero-extended to 64 bits. Code 0 gives bits 7:0, code 1 gives bits 15:8, code 2 gives bits 15:0, code 3 gives bits 31:0 and code 4 gives bits 63:0.
- R8: Code 1 with an index of 4 or above, and any size code from 5 to 7, raises that port's illegal output in the same cycle. Such a write changes no register, and such a read returns zero.
- R9: A read of a register that is being written in the same cycle returns the old value; the new value appears after the clock edge. Both read ports work independently.
- R10: While wr_en is low, no register changes, whatever is on the write index, size and data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write view code |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Write view/index combination is illegal |
| rda_idx | input | 4 | Port A register index |
| rda_size | input | 3 | Port A view code |
| rda_data | output | 64 | Port A zero-extended result |
| rda_illegal | output | 1 | Port A combination is illegal |
| rdb_idx | input | 4 | Port B register index |
| rdb_size | input | 3 | Port B view code |
| rdb_data | output | 64 | Port B zero-extended result |
| rdb_illegal | output | 1 | Port B combination is illegal |

## Verification
The bench goes after the merge rules first. A 32-bit write that fails to clear the upper half leaves stale bits visible in the full view. A byte or halfword write that replaces the whole register wipes bits that the bench had seeded with non-zero patterns. The high-byte view is exercised on legal and illegal indices, and with undefined size codes. A design that forgets to suppress these writes corrupts a register, and one that slices the wrong byte returns the low byte. A same-cycle read-during-write check catches a design that forwards the new value.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  typedef enum logic [2:0] {
    VW_BLO  = 3'd0,
    VW_BHI  = 3'd1,
    VW_HALF = 3'd2,
    VW_WORD = 3'd3,
    VW_FULL = 3'd4
  } view_e;
endpackage

// File: rtl/alias_view_check.sv
module alias_view_check #(
  parameter int IDXW    = 4,
  parameter int HB_REGS = 4
) (
  input  logic [IDXW-1:0] idx,
  input  logic [2:0]      size,
  output logic            legal
);
  import alias_rf_pkg::*;

  always_comb begin
    unique case (size)
      VW_BLO, VW_HALF, VW_WORD, VW_FULL: legal = 1'b1;
      VW_BHI:  legal = (idx < IDXW'(HB_REGS));
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alias_read_slice.sv
module alias_read_slice #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] reg_val,
  input  logic [2:0]      size,
  input  logic            legal,
  output logic [XLEN-1:0] data
);
  import alias_rf_pkg::*;
  localparam int HALFW = XLEN / 2;

  always_comb begin
    data = '0;
    if (legal) begin
      unique case (size)
        VW_BLO:  data = {{(XLEN-8){1'b0}},  reg_val[7:0]};
        VW_BHI:  data = {{(XLEN-8){1'b0}},  reg_val[15:8]};
        VW_HALF: data = {{(XLEN-16){1'b0}}, reg_val[15:0]};
        VW_WORD: data = {{(XLEN-HALFW){1'b0}}, reg_val[HALFW-1:0]};
        VW_FULL: data = reg_val;
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/alias_write_merge.sv
module alias_write_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wr_data,
  input  logic [2:0]      size,
  output logic [XLEN-1:0] new_val
);
  import alias_rf_pkg::*;
  localparam int HALFW = XLEN / 2;

  always_comb begin
    unique case (size)
      VW_BLO:  new_val = {old_val[XLEN-1:8], wr_data[7:0]};
      VW_BHI:  new_val = {old_val[XLEN-1:16], wr_data[7:0], old_val[7:0]};
      VW_HALF: new_val = {old_val[XLEN-1:16], wr_data[15:0]};
      VW_WORD: new_val = {{(XLEN-HALFW){1'b0}}, wr_data[HALFW-1:0]};
      VW_FULL: new_val = wr_data;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int NUM_REGS = 16,
  parameter int XLEN     = 64,
  parameter int HB_REGS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [2:0]                  wr_size,
  input  logic [XLEN-1:0]             wr_data,
  output logic                        wr_illegal,
  input  logic [$clog2(NUM_REGS)-1:0] rda_idx,
  input  logic [2:0]                  rda_size,
  output logic [XLEN-1:0]             rda_data,
  output logic                        rda_illegal,
  input  logic [$clog2(NUM_REGS)-1:0] rdb_idx,
  input  logic [2:0]                  rdb_size,
  output logic [XLEN-1:0]             rdb_data,
  output logic                        rdb_illegal
);
  localparam int IDXW  = $clog2(NUM_REGS);
  localparam int HALFW = XLEN / 2;

  logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
  logic [NUM_REGS-1:0]           ld_en;
  logic [XLEN-1:0]               merged;
  logic                          wr_legal, rda_legal, rdb_legal;

  // legality per port
  alias_view_check #(.IDXW(IDXW), .HB_REGS(HB_REGS)) u_chk_w (
    .idx(wr_idx), .size(wr_size), .legal(wr_legal));
  alias_view_check #(.IDXW(IDXW), .HB_REGS(HB_REGS)) u_chk_a (
    .idx(rda_idx), .size(rda_size), .legal(rda_legal));
  alias_view_check #(.IDXW(IDXW), .HB_REGS(HB_REGS)) u_chk_b (
    .idx(rdb_idx), .size(rdb_size), .legal(rdb_legal));

  assign wr_illegal  = ~wr_legal;
  assign rda_illegal = ~rda_legal;
  assign rdb_illegal = ~rdb_legal;

  // next value of the addressed register
  alias_write_merge #(.XLEN(XLEN)) u_merge (
    .old_val(regs_q[wr_idx]), .wr_data(wr_data),
    .size(wr_size), .new_val(merged));

  // storage: one enable and one register process per entry
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_comb begin
      ld_en[g] = wr_en & wr_legal & (wr_idx == IDXW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (ld_en[g]) begin
        regs_q[g] <= merged;
      end
    end
  end

  // read ports see the pre-edge contents
  alias_read_slice #(.XLEN(XLEN)) u_rd_a (
    .reg_val(regs_q[rda_idx]), .size(rda_size),
    .legal(rda_legal), .data(rda_data));
  alias_read_slice #(.XLEN(XLEN)) u_rd_b (
    .reg_val(regs_q[rdb_idx]), .size(rdb_size),
    .legal(rdb_legal), .data(rdb_data));

  // R3: 32-bit write leaves the upper half zero
  a_r3_word_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'd3) |=> (regs_q[$past(wr_idx)][XLEN-1:HALFW] == '0));

  // R5: low-byte write keeps bits above the byte
  a_r5_byte_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'd0) |=>
      (regs_q[$past(wr_idx)][XLEN-1:8] == $past(regs_q[wr_idx][XLEN-1:8])));

  // R7: narrow views on port A are zero-extended
  a_r7_read_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_size != 3'd4) |-> (rda_data[XLEN-1:HALFW] == '0));

  // R8: flagged write changes nothing
  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_illegal) |=> (regs_q == $past(regs_q)));

  // R8: flagged read on port B returns zero
  a_r8_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdb_illegal |-> (rdb_data == '0));

  // R10: idle write port holds all state
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (regs_q == $past(regs_q)));
endmodule

// File: tb/sim_alias_regfile.sv
module sim_alias_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [2:0]  wr_size;
  logic [63:0] wr_data;
  logic        wr_illegal;
  logic [3:0]  rda_idx, rdb_idx;
  logic [2:0]  rda_size, rdb_size;
  logic [63:0] rda_data, rdb_data;
  logic        rda_illegal, rdb_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] mdl [16];

  always #4 clk = ~clk;

  alias_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rda_idx(rda_idx), .rda_size(rda_size), .rda_data(rda_data), .rda_illegal(rda_illegal),
    .rdb_idx(rdb_idx), .rdb_size(rdb_size), .rdb_data(rdb_data), .rdb_illegal(rdb_illegal));

  function automatic bit exp_bad(input logic [3:0] idx, input logic [2:0] sz);
    return (sz == 3'd1 && idx >= 4'd4) || (sz > 3'd4);
  endfunction

  function automatic logic [63:0] exp_view(input logic [63:0] v, input logic [2:0] sz);
    case (sz)
      3'd0: return {56'd0, v[7:0]};
      3'd1: return {56'd0, v[15:8]};
      3'd2: return {48'd0, v[15:0]};
      3'd3: return {32'd0, v[31:0]};
      3'd4: return v;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] exp_store(input logic [63:0] o, input logic [63:0] d,
                                            input logic [2:0] sz);
    case (sz)
      3'd0: return {o[63:8], d[7:0]};
      3'd1: return {o[63:16], d[7:0], o[7:0]};
      3'd2: return {o[63:16], d[15:0]};
      3'd3: return {32'd0, d[31:0]};
      3'd4: return d;
      default: return o;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input bit port_b, input logic [3:0] idx,
                    input logic [2:0] sz);
    if (port_b) begin rdb_idx = idx; rdb_size = sz; end
    else begin rda_idx = idx; rda_size = sz; end
    #1;
    if (port_b) begin
      check(req, rdb_data, exp_bad(idx, sz) ? 64'd0 : exp_view(mdl[idx], sz));
      check(req, {63'd0, rdb_illegal}, {63'd0, exp_bad(idx, sz)});
    end else begin
      check(req, rda_data, exp_bad(idx, sz) ? 64'd0 : exp_view(mdl[idx], sz));
      check(req, {63'd0, rda_illegal}, {63'd0, exp_bad(idx, sz)});
    end
  endtask

  task automatic wr(input string req, input logic [3:0] idx, input logic [2:0] sz,
                    input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
    #1;
    check(req, {63'd0, wr_illegal}, {63'd0, exp_bad(idx, sz)});
    @(negedge clk);
    wr_en = 1'b0;
    if (!exp_bad(idx, sz)) mdl[idx] = exp_store(mdl[idx], d, sz);
  endtask

  task automatic t_reset;  // R1
    for (int i = 0; i < 16; i++) begin
      rd("R1", 1'b0, 4'(i), 3'd4);
      rd("R1", 1'b1, 4'(i), 3'd4);
    end
  endtask

  task automatic t_full;  // R2
    for (int i = 0; i < 16; i++)
      wr("R2", 4'(i), 3'd4, {8'(i), 56'h5A_C3F0_1E2D_3C4B} ^ 64'hFFFF_0000_FFFF_0000);
    for (int i = 0; i < 16; i++) rd("R2", i[0], 4'(i), 3'd4);
  endtask

  task automatic t_word;  // R3
    wr("R3", 4'd9, 3'd3, 64'h1111_2222_8765_4321);
    rd("R3", 1'b0, 4'd9, 3'd4);
    wr("R3", 4'd14, 3'd3, 64'hFFFF_FFFF_0000_0000);
    rd("R3", 1'b1, 4'd14, 3'd4);
  endtask

  task automatic t_half;  // R4
    wr("R4", 4'd12, 3'd2, 64'hAAAA_BBBB_CCCC_BEEF);
    rd("R4", 1'b0, 4'd12, 3'd4);
    wr("R4", 4'd7, 3'd2, 64'h0);
    rd("R4", 1'b1, 4'd7, 3'd4);
  endtask

  task automatic t_blo;  // R5
    wr("R5", 4'd15, 3'd0, 64'hFFFF_FFFF_FFFF_FF99);
    rd("R5", 1'b0, 4'd15, 3'd4);
    wr("R5", 4'd1, 3'd0, 64'h0);
    rd("R5", 1'b1, 4'd1, 3'd4);
  endtask

  task automatic t_bhi;  // R6
    wr("R6", 4'd2, 3'd1, 64'h0000_0000_0000_00A5);
    rd("R6", 1'b0, 4'd2, 3'd4);
    wr("R6", 4'd3, 3'd1, 64'hFFFF_FFFF_FFFF_FF3C);
    rd("R6", 1'b1, 4'd3, 3'd4);
  endtask

  task automatic t_views;  // R7
    for (int i = 0; i < 4; i++)
      for (int s = 0; s < 5; s++) rd("R7", s[0], 4'(i), 3'(s));
    rd("R7", 1'b0, 4'd11, 3'd3);
    rd("R7", 1'b1, 4'd11, 3'd2);
  endtask

  task automatic t_illegal;  // R8
    wr("R8", 4'd6, 3'd1, 64'h0000_0000_0000_0077);
    rd("R8", 1'b0, 4'd6, 3'd4);
    wr("R8", 4'd1, 3'd7, 64'h1234_5678_9ABC_DEF0);
    rd("R8", 1'b0, 4'd1, 3'd4);
    wr("R8", 4'd4, 3'd5, 64'h0);
    rd("R8", 1'b1, 4'd4, 3'd4);
    rd("R8", 1'b1, 4'd10, 3'd1);
    rd("R8", 1'b0, 4'd0, 3'd6);
  endtask

  task automatic t_same_cycle;  // R9
    logic [63:0] oldv;
    oldv = mdl[5];
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd5; wr_size = 3'd4; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
    rda_idx = 4'd5; rda_size = 3'd4;
    rdb_idx = 4'd5; rdb_size = 3'd0;
    #1;
    check("R9", rda_data, oldv);
    check("R9", rdb_data, {56'd0, oldv[7:0]});
    @(negedge clk);
    wr_en = 1'b0;
    mdl[5] = 64'hDEAD_BEEF_0BAD_F00D;
    #1;
    check("R9", rda_data, mdl[5]);
    check("R9", rdb_data, {56'd0, mdl[5][7:0]});
  endtask

  task automatic t_idle;  // R10
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd8; wr_size = 3'd4; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
    @(negedge clk);
    @(negedge clk);
    rd("R10", 1'b0, 4'd8, 3'd4);
    rd("R10", 1'b1, 4'd8, 3'd3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
    rda_idx = '0; rda_size = 3'd4; rdb_idx = '0; rdb_size = 3'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_word();
    t_half();
    t_blo();
    t_bhi();
    t_views();
    t_illegal();
    t_same_cycle();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule